// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block is the issue stage of one compute unit that feeds four lockstep SIMT pipelines. Each pipeline owns a small table of resident wavefront slots. Wavefronts are allocated into these slots and retired from them through per-pipeline request lines. Every cycle the scheduler gives the turn to exactly one pipeline, in a fixed rotation. If that pipeline has a resident wavefront whose next instruction is ready, the scheduler issues that wavefront.

An issued 64-lane wavefront instruction occupies its pipeline's 16-lane ALU for four consecutive cycles, one lane quarter per cycle. The rotation brings each pipeline back every fourth cycle, so a fully loaded unit starts one wavefront instruction per cycle while every ALU stays busy. The block also reports the number of active work-items in the unit and the quarter each pipeline is executing.

All per-pipeline buses are flattened: the field for pipeline `p` sits at `[p*W +: W]`. The ready vector `wf_ready` carries one bit per slot at index `p*SLOTS + s`.

Top module: `wavefront_issue_sched`

## Requirements
- R1: After reset, no slot is resident, `alloc_ready` is all ones, `occ_items` is 0, `exec_active` is 0, `issue_valid` is 0, and the first cycle after reset gives the turn to pipeline 0.
- R2: `issue_pipe` names the pipeline that has the turn. It advances 0, 1, 2, 3, 0 by one every cycle, and it advances even when no issue happens (a bubble). At most one pipeline starts an instruction per cycle.
- R3: `issue_valid` is 1 only when the pipeline that has the turn holds a slot that is both resident and marked ready in `wf_ready`. If no such slot exists, the cycle is a bubble. A ready bit on a non-resident slot never causes an issue.
- R4: Within a pipeline, the issued slot (a 4-bit index, 0 to 9) is the first resident ready slot found when searching upward from the slot after that pipeline's last issued slot, wrapping from 9 to 0. After reset the search starts at slot 0. A bubble leaves the search point unchanged.
- R5: A pipeline that issues in cycle t has `exec_active[p]` high in cycles t to t+3, with a 2-bit `exec_qtr` of 0, 1, 2 and 3 in turn. These values cover lanes 0-15, 16-31, 32-47 and 48-63. The pipeline is not issued again while it is active.
- R6: A pipeline with at least one free slot shows `alloc_ready` high. An accepted allocation fills the lowest-numbered free slot, and `alloc_slot` shows that index in the request cycle. When all 10 slots are resident, `alloc_ready` is low and a request changes nothing.
- R7: A retire of a resident slot frees it at the next clock edge, so it can be allocated again in the following cycle. A retire that names a free slot, or an index of 10 or more, has no effect.
- R8: `occ_items` equals 64 times the number of resident wavefronts, updated one cycle after each allocation or retire. It reaches 2560 with all 40 slots resident and never exceeds 2560.
- R9: With every slot resident and ready, an instruction issues in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| alloc_valid | input | 4 | Per-pipeline request to make a new wavefront resident |
| alloc_ready | output | 4 | Per-pipeline: at least one slot free |
| alloc_slot | output | 16 | Per-pipeline slot index a request would fill (4 bits each) |
| retire_valid | input | 4 | Per-pipeline request to free a slot |
| retire_slot | input | 16 | Per-pipeline slot index to free (4 bits each) |
| wf_ready | input | 40 | Per-slot flag: next instruction may issue |
| issue_valid | output | 1 | An instruction starts this cycle |
| issue_pipe | output | 2 | Pipeline holding the turn this cycle |
| issue_slot | output | 4 | Slot issued this cycle (meaningful with issue_valid) |
| exec_active | output | 4 | Per-pipeline: ALU executing a wavefront instruction |
| exec_qtr | output | 8 | Per-pipeline lane quarter in execution (2 bits each) |
| occ_items | output | 12 | Active work-items in the unit |

## Verification
The assertions take for granted that `rst_n` is released synchronously. They also assume `wf_ready` and the allocate and retire lines are stable from the drive point until the next rising edge, and that a caller never allocates and retires the same slot index in one cycle. The stimulus drives every input on the falling edge and samples half a nanosecond later, before the next rising edge. It allocates only through `alloc_slot` as the block reports it, and it sends retires with out-of-range indices or for free slots only as deliberate no-effect cases. The ready masks are applied identically to all four pipelines for a whole rotation, so every pipeline's round-robin history stays the same and one expected slot serves all four.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned WIS_PIPES     = 4;   // SIMT pipelines per compute unit
  localparam int unsigned WIS_SLOTS     = 10;  // resident wavefronts per pipeline
  localparam int unsigned WIS_WF_LANES  = 64;  // work-items per wavefront
  localparam int unsigned WIS_ALU_LANES = 16;  // physical ALU width
endpackage

// File: rtl/wis_slot_table.sv
// Resident-slot table of one pipeline: allocation, retire, round-robin pick.
module wis_slot_table #(
  parameter int unsigned SLOTS = 10,
  parameter int unsigned SW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             free_any,
  output logic [SW-1:0]    free_idx,
  input  logic             retire_req,
  input  logic [SW-1:0]    retire_idx,
  output logic             retire_hit,
  input  logic [SLOTS-1:0] rdy,
  input  logic             pick_take,
  output logic             pick_found,
  output logic [SW-1:0]    pick_idx
);
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [SW-1:0]    rr_q;

  // lowest free slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[SW'(i)]) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
    end
  end

  // retire matches only a resident, in-range slot
  always_comb begin
    retire_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (retire_req && (retire_idx == SW'(i)) && vld_q[SW'(i)]) retire_hit = 1'b1;
    end
  end

  // round-robin search starting after the last issued slot
  always_comb begin
    int c;
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int k = SLOTS; k >= 1; k--) begin
      c = (int'(rr_q) + k) % int'(SLOTS);
      if (vld_q[SW'(c)] && rdy[SW'(c)]) begin
        pick_found = 1'b1;
        pick_idx   = SW'(c);
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < SLOTS; i++) begin
      if (retire_req && (retire_idx == SW'(i))) vld_d[SW'(i)] = 1'b0;
    end
    if (alloc_req && free_any) vld_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= SW'(SLOTS - 1);
    end else begin
      vld_q <= vld_d;
      if (pick_take) rr_q <= pick_idx;
    end
  end

  AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && free_any) |=> vld_q[$past(free_idx)]);                // R6
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    retire_hit |=> !vld_q[$past(retire_idx)]);                          // R7
  AST_PICK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pick_take |-> (vld_q[pick_idx] && rdy[pick_idx]));                  // R3
endmodule

// File: rtl/wis_qtr_seq.sv
// Steps one pipeline's ALU through the lane quarters of a wavefront instruction.
module wis_qtr_seq #(
  parameter int unsigned QUARTERS = 4,
  parameter int unsigned QW       = $clog2(QUARTERS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          idle,
  output logic          active,
  output logic [QW-1:0] qtr
);
  logic [QW-1:0] cnt_q, cnt_d;

  assign idle   = (cnt_q == '0);
  assign active = start || !idle;
  assign qtr    = start ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = QW'(1);
    else if (!idle) cnt_d = (cnt_q == QW'(QUARTERS - 1)) ? '0 : cnt_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);                                                    // R5
  AST_QTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (qtr != QW'(QUARTERS - 1))) |=> (active && (qtr == $past(qtr) + QW'(1)))); // R5
endmodule

// File: rtl/wis_occ_counter.sv
// Saturating count of active work-items.
module wis_occ_counter #(
  parameter int unsigned CAP  = 2560,
  parameter int unsigned STEP = 64,
  parameter int unsigned CW   = $clog2(CAP + 1),
  parameter int unsigned NW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_add,
  input  logic [NW-1:0] n_sub,
  output logic [CW-1:0] occ
);
  logic [CW-1:0] occ_q, occ_d;
  logic          upd;

  assign upd = (n_add != n_sub);

  always_comb begin
    int nxt;
    nxt = int'(occ_q) + (int'(n_add) - int'(n_sub)) * int'(STEP);
    if (nxt > int'(CAP)) nxt = int'(CAP);
    if (nxt < 0)         nxt = 0;
    occ_d = CW'(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   occ_q <= '0;
    else if (upd) occ_q <= occ_d;
  end

  assign occ = occ_q;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(CAP));                                                 // R8
  AST_OCC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (n_add == '0 && n_sub == '0) |=> $stable(occ_q));                  // R8
endmodule

// File: rtl/wavefront_issue_sched.sv
module wavefront_issue_sched #(
  parameter int unsigned NUM_PIPES = wis_pkg::WIS_PIPES,
  parameter int unsigned SLOTS     = wis_pkg::WIS_SLOTS,
  parameter int unsigned WF_LANES  = wis_pkg::WIS_WF_LANES,
  parameter int unsigned ALU_LANES = wis_pkg::WIS_ALU_LANES,
  parameter int unsigned PW        = $clog2(NUM_PIPES),
  parameter int unsigned SW        = $clog2(SLOTS),
  parameter int unsigned QUARTERS  = WF_LANES / ALU_LANES,
  parameter int unsigned QW        = $clog2(QUARTERS),
  parameter int unsigned OCC_CAP   = NUM_PIPES * SLOTS * WF_LANES,
  parameter int unsigned OCC_W     = $clog2(OCC_CAP + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PIPES-1:0]      alloc_valid,
  output logic [NUM_PIPES-1:0]      alloc_ready,
  output logic [NUM_PIPES*SW-1:0]   alloc_slot,
  input  logic [NUM_PIPES-1:0]      retire_valid,
  input  logic [NUM_PIPES*SW-1:0]   retire_slot,
  input  logic [NUM_PIPES*SLOTS-1:0] wf_ready,
  output logic                      issue_valid,
  output logic [PW-1:0]             issue_pipe,
  output logic [SW-1:0]             issue_slot,
  output logic [NUM_PIPES-1:0]      exec_active,
  output logic [NUM_PIPES*QW-1:0]   exec_qtr,
  output logic [OCC_W-1:0]          occ_items
);
  localparam int unsigned NW = $clog2(NUM_PIPES + 1);

  logic [PW-1:0]        rot_q, rot_d;
  logic [NUM_PIPES-1:0] found, take, idle, hit;
  logic [SW-1:0]        pick_a [NUM_PIPES];
  logic [NW-1:0]        n_add, n_sub;

  // rotation: one pipeline holds the turn each cycle
  assign rot_d = (rot_q == PW'(NUM_PIPES - 1)) ? '0 : rot_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rot_q <= '0;
    else        rot_q <= rot_d;
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign take[p] = (rot_q == PW'(p)) && found[p] && idle[p];

      wis_slot_table #(.SLOTS(SLOTS), .SW(SW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_valid[p]),
        .free_any   (alloc_ready[p]),
        .free_idx   (alloc_slot[p*SW +: SW]),
        .retire_req (retire_valid[p]),
        .retire_idx (retire_slot[p*SW +: SW]),
        .retire_hit (hit[p]),
        .rdy        (wf_ready[p*SLOTS +: SLOTS]),
        .pick_take  (take[p]),
        .pick_found (found[p]),
        .pick_idx   (pick_a[p])
      );

      wis_qtr_seq #(.QUARTERS(QUARTERS), .QW(QW)) u_qtr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (take[p]),
        .idle   (idle[p]),
        .active (exec_active[p]),
        .qtr    (exec_qtr[p*QW +: QW])
      );
    end
  endgenerate

  always_comb begin
    issue_slot = '0;
    n_add      = '0;
    n_sub      = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (rot_q == PW'(i)) issue_slot = pick_a[i];
      n_add = n_add + NW'(alloc_valid[i] & alloc_ready[i]);
      n_sub = n_sub + NW'(hit[i]);
    end
  end

  assign issue_valid = |take;
  assign issue_pipe  = rot_q;

  wis_occ_counter #(.CAP(OCC_CAP), .STEP(WF_LANES), .CW(OCC_W), .NW(NW)) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .n_add (n_add),
    .n_sub (n_sub),
    .occ   (occ_items)
  );

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));                                                    // R2
  AST_TURN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (issue_pipe != $past(issue_pipe)));                        // R2
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> exec_active[issue_pipe]);                           // R5
endmodule

// File: tb/wavefront_issue_sched_tb.sv
`timescale 1ns/100ps
module wavefront_issue_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  alloc_valid, alloc_ready, retire_valid, exec_active;
  logic [15:0] alloc_slot, retire_slot;
  logic [39:0] wf_ready;
  logic        issue_valid;
  logic [1:0]  issue_pipe;
  logic [3:0]  issue_slot;
  logic [7:0]  exec_qtr;
  logic [11:0] occ_items;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int rot_exp = 0;

  always #2 clk = ~clk;   // 250 MHz

  wavefront_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
    .retire_valid(retire_valid), .retire_slot(retire_slot), .wf_ready(wf_ready),
    .issue_valid(issue_valid), .issue_pipe(issue_pipe), .issue_slot(issue_slot),
    .exec_active(exec_active), .exec_qtr(exec_qtr), .occ_items(occ_items)
  );

  // expected turn, from R1/R2
  always @(posedge clk) begin
    if (!rst_n) rot_exp <= 0;
    else        rot_exp <= (rot_exp + 1) % 4;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {ready mask per pipeline, expected issue, expected slot}
  localparam logic [14:0] VEC [0:9] = '{
    {10'h3FF, 1'b1, 4'd0},
    {10'h3FF, 1'b1, 4'd1},
    {10'h020, 1'b1, 4'd5},
    {10'h084, 1'b1, 4'd7},
    {10'h084, 1'b1, 4'd2},
    {10'h000, 1'b0, 4'd0},
    {10'h004, 1'b1, 4'd2},
    {10'h201, 1'b1, 4'd9},
    {10'h201, 1'b1, 4'd0},
    {10'h3FF, 1'b1, 4'd1}
  };

  initial begin
    rst_n = 1'b0; alloc_valid = '0; retire_valid = '0; retire_slot = '0; wf_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1 pipe", int'(issue_pipe), 0);
    chk("R1 issue", int'(issue_valid), 0);
    chk("R1 ready", int'(alloc_ready), 15);
    chk("R1 occ", int'(occ_items), 0);
    chk("R1 exec", int'(exec_active), 0);

    // fill all slots, lowest first (R6)
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); alloc_valid = 4'hF; #0.5;
      for (int q = 0; q < 4; q++) chk("R6 slot", int'(alloc_slot[q*4 +: 4]), k);
      chk("R3 bubble", int'(issue_valid), 0);
    end
    @(negedge clk); #0.5;
    chk("R6 full", int'(alloc_ready), 0);
    chk("R8 cap", int'(occ_items), 2560);
    @(negedge clk); alloc_valid = '0; #0.5;
    chk("R6 refused", int'(occ_items), 2560);

    // round-robin vectors, one full rotation per row (R2 R3 R4 R5)
    for (int r = 0; r < 10; r++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); wf_ready = {4{VEC[r][14:5]}}; #0.5;
        chk("R2 turn", int'(issue_pipe), rot_exp);
        chk("R3 valid", int'(issue_valid), int'(VEC[r][4]));
        if (VEC[r][4]) begin
          chk("R4 slot", int'(issue_slot), int'(VEC[r][3:0]));
          chk("R5 start", int'(exec_qtr[rot_exp*2 +: 2]), 0);
        end
      end
    end

    // steady state: one issue per cycle, quarters staggered (R9 R5)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); wf_ready = '1; #0.5;
      chk("R9 issue", int'(issue_valid), 1);
      chk("R5 active", int'(exec_active), 15);
      for (int q = 0; q < 4; q++)
        chk("R5 quarter", int'(exec_qtr[q*2 +: 2]), (rot_exp - q + 4) % 4);
    end

    // retire and reuse (R7)
    @(negedge clk); wf_ready = '0; retire_valid = 4'b0010; retire_slot = 16'h0030; #0.5;
    @(negedge clk); retire_valid = 4'b0011; retire_slot = 16'h003C; #0.5;
    chk("R7 occ", int'(occ_items), 2496);
    chk("R7 ready", int'(alloc_ready), 2);
    chk("R7 slot", int'(alloc_slot[7:4]), 3);
    @(negedge clk); retire_valid = '0; #0.5;
    chk("R7 ignored occ", int'(occ_items), 2496);
    chk("R7 ignored ready", int'(alloc_ready), 2);
    @(negedge clk); alloc_valid = 4'b0010; #0.5;
    chk("R6 reuse", int'(alloc_slot[7:4]), 3);
    @(negedge clk); alloc_valid = '0; #0.5;
    chk("R8 back", int'(occ_items), 2560);
    chk("R6 full again", int'(alloc_ready), 0);

    // ready bit on a free slot does not issue (R3)
    @(negedge clk); retire_valid = 4'b0100; retire_slot = 16'h0400; #0.5;
    @(negedge clk); retire_valid = '0;
    wf_ready = (40'd1 << 24) | (40'd1 << 34); #0.5;
    while (rot_exp != 2) begin @(negedge clk); #0.5; end
    chk("R3 free slot", int'(issue_valid), 0);
    @(negedge clk); #0.5;
    chk("R3 resident", int'(issue_valid), 1);
    chk("R4 only ready", int'(issue_slot), 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1: watchdog, actual 0 expected 1 completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule